// File: doc/BRIEF.md
# VT1.5 Time Slot Interchange

This block switches VT1.5 tributaries between STS-1 streams. It terminates 24 STS-1 ports of 28 VT1.5 positions each, 672 positions per frame. A connection table, written through a small configuration port, names a source position for every output position. Any VT1.5 can reach any port and any position of any other STS-1, rather than staying in the position it arrived in. The switch is nonblocking, and one source may feed several outputs.

Input words arrive one per cycle with a strobe and a port/VT index, in sequential slot order. Every position of every port is stored, mapped or not, in one bank of a two-bank data store. The other bank, which holds the previous frame, is read in the order the connection table gives. The banks swap when the last position of a frame (port 23, VT 27) is strobed. Table writes go to a pending copy, which is committed to the active copy at that same frame boundary, so no frame ever sees a partial remap. An output position with no connection, or with no complete stored frame behind it, carries all ones.

Top module: `vt_tsi_switch`

## Requirements
- R1: After reset the output strobe is low and every connection entry reads back as disconnected.
- R2: Each input strobe for port p (0..23) and VT v (0..27) produces exactly one output strobe in the next cycle, with the same p and v as the output position. With no input strobe, the output strobe is low in the next cycle.
- R3: Output position k = p*28+v of frame N carries the word received at its connected source position in frame N-1, for any source and any destination.
- R4: One source position connected to several destinations delivers the same word to each of them.
- R5: An output position whose active entry is disconnected carries 8'hFF (all ones).
- R6: Until one full frame has been stored, every output position carries all ones.
- R7: A configuration write stores the connect flag and the source port and VT for the addressed destination. The readback port shows the pending entry for the addressed destination combinationally, from the cycle after the write.
- R8: Entries written before the cycle that strobes the last position (port 23, VT 27) take effect from the first position of the next frame. A write made mid-frame leaves the rest of that frame unchanged.
- R9: All 672 output positions may be connected at once with no blocking, for example as a full reversal of positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inStrobe | input | 1 | Input word valid |
| inPort | input | 5 | Input STS-1 port index, 0..23 |
| inVt | input | 5 | Input VT1.5 position, 0..27 |
| inData | input | 8 | Input VT word |
| outStrobe | output | 1 | Output word valid |
| outPort | output | 5 | Output STS-1 port index |
| outVt | output | 5 | Output VT1.5 position |
| outData | output | 8 | Output VT word, all ones when idle |
| cfgWe | input | 1 | Connection entry write enable |
| cfgPort | input | 5 | Destination port for write and readback |
| cfgVt | input | 5 | Destination VT for write and readback |
| cfgConnect | input | 1 | Connect flag to write |
| cfgSrcPort | input | 5 | Source port to write |
| cfgSrcVt | input | 5 | Source VT to write |
| rdConnect | output | 1 | Pending connect flag at the addressed destination |
| rdSrcPort | output | 5 | Pending source port at the addressed destination |
| rdSrcVt | output | 5 | Pending source VT at the addressed destination |

## Verification
The data word depends on both the frame number and the slot index, so a one-frame delay, a wrong bank or a wrong source index each show up as a distinct mismatch. The patterns used are a sparse map with corner positions (port 23 VT 27 to port 0 VT 0) and a two-way multicast, a mid-frame rewrite that must not show until the next frame, and a full reversal that connects all 672 outputs at once. The first frame after reset separates the idle output from stale store contents. Every output slot is compared on data, port and VT.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int NUM_PORTS = 24;
  parameter int NUM_VTS   = 28;
  parameter int WORD_W    = 8;
  localparam int TOTAL    = NUM_PORTS * NUM_VTS;
  localparam int PORT_W   = $clog2(NUM_PORTS);
  localparam int VT_W     = $clog2(NUM_VTS);
  localparam int IDX_W    = $clog2(TOTAL);

  typedef struct packed {
    logic              conn;
    logic [PORT_W-1:0] srcPort;
    logic [VT_W-1:0]   srcVt;
  } connEntry_t;

  typedef struct packed {
    logic              wrEn;
    logic              wrBank;
    logic [IDX_W-1:0]  wrIdx;
    logic              rdHit;
    logic [IDX_W-1:0]  rdIdx;
    logic [PORT_W-1:0] port;
    logic [VT_W-1:0]   vt;
  } dpStrobe_t;

  function automatic logic [IDX_W-1:0] toIdx(logic [PORT_W-1:0] p, logic [VT_W-1:0] v);
    return IDX_W'(p) * IDX_W'(NUM_VTS) + IDX_W'(v);
  endfunction
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inStrobe,
  input  logic [PORT_W-1:0] inPort,
  input  logic [VT_W-1:0]   inVt,
  input  logic              cfgWe,
  input  logic [PORT_W-1:0] cfgPort,
  input  logic [VT_W-1:0]   cfgVt,
  input  connEntry_t        cfgEntry,
  output connEntry_t        rdEntry,
  output dpStrobe_t         strobes
);
  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);
  localparam logic [VT_W-1:0]   LAST_VT   = VT_W'(NUM_VTS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(TOTAL - 1);

  connEntry_t pendMap [TOTAL];
  connEntry_t actMap  [TOTAL];
  logic       wrBank;
  logic       frameReady;
  logic [IDX_W-1:0] inIdx;
  logic       lastSlot;
  connEntry_t curEntry;

  assign inIdx    = toIdx(inPort, inVt);
  assign lastSlot = inStrobe && (inIdx == LAST_IDX);
  assign curEntry = actMap[inIdx];
  assign rdEntry  = pendMap[toIdx(cfgPort, cfgVt)];

  always_comb begin
    strobes.wrEn   = inStrobe;
    strobes.wrBank = wrBank;
    strobes.wrIdx  = inIdx;
    strobes.rdHit  = inStrobe && frameReady && curEntry.conn;
    strobes.rdIdx  = toIdx(curEntry.srcPort, curEntry.srcVt);
    strobes.port   = inPort;
    strobes.vt     = inVt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBank     <= 1'b0;
      frameReady <= 1'b0;
      for (int i = 0; i < TOTAL; i++) begin
        pendMap[i] <= '0;
        actMap[i]  <= '0;
      end
    end else begin
      if (cfgWe) pendMap[toIdx(cfgPort, cfgVt)] <= cfgEntry;
      if (lastSlot) begin
        wrBank     <= ~wrBank;
        frameReady <= 1'b1;
        actMap     <= pendMap;
      end
    end
  end

  // R2: input index must name a real position
  p_in_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    inStrobe |-> (inPort <= LAST_PORT && inVt <= LAST_VT));

  // R7: configuration address and source must be real positions
  p_cfg_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |-> (cfgPort <= LAST_PORT && cfgVt <= LAST_VT &&
               cfgEntry.srcPort <= LAST_PORT && cfgEntry.srcVt <= LAST_VT));

  // R8: banks only swap on the last position of a frame
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !lastSlot |=> $stable(wrBank));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [WORD_W-1:0] inData,
  output logic              outStrobe,
  output logic [PORT_W-1:0] outPort,
  output logic [VT_W-1:0]   outVt,
  output logic [WORD_W-1:0] outData
);
  localparam int NUM_BANKS = 2;

  logic [WORD_W-1:0] dataMem [NUM_BANKS][TOTAL];
  logic [WORD_W-1:0] rdWord;

  assign rdWord = dataMem[~strobes.wrBank][strobes.rdIdx];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) dataMem[strobes.wrBank][strobes.wrIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outStrobe <= 1'b0;
      outPort   <= '0;
      outVt     <= '0;
      outData   <= '1;
    end else begin
      outStrobe <= strobes.wrEn;
      if (strobes.wrEn) begin
        outPort <= strobes.port;
        outVt   <= strobes.vt;
        outData <= strobes.rdHit ? rdWord : '1;
      end
    end
  end

  // R2: one output strobe per input strobe, one cycle later
  p_strobe_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> outStrobe);
  p_strobe_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEn |=> !outStrobe);

  // R5: positions without a live connection carry the idle pattern
  p_idle_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrEn && !strobes.rdHit) |=> (outData == '1));
endmodule

// File: rtl/vt_tsi_switch.sv
module vt_tsi_switch
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inStrobe,
  input  logic [PORT_W-1:0] inPort,
  input  logic [VT_W-1:0]   inVt,
  input  logic [WORD_W-1:0] inData,
  output logic              outStrobe,
  output logic [PORT_W-1:0] outPort,
  output logic [VT_W-1:0]   outVt,
  output logic [WORD_W-1:0] outData,
  input  logic              cfgWe,
  input  logic [PORT_W-1:0] cfgPort,
  input  logic [VT_W-1:0]   cfgVt,
  input  logic              cfgConnect,
  input  logic [PORT_W-1:0] cfgSrcPort,
  input  logic [VT_W-1:0]   cfgSrcVt,
  output logic              rdConnect,
  output logic [PORT_W-1:0] rdSrcPort,
  output logic [VT_W-1:0]   rdSrcVt
);
  dpStrobe_t  strobes;
  connEntry_t cfgEntry;
  connEntry_t rdEntry;

  assign cfgEntry  = '{conn: cfgConnect, srcPort: cfgSrcPort, srcVt: cfgSrcVt};
  assign rdConnect = rdEntry.conn;
  assign rdSrcPort = rdEntry.srcPort;
  assign rdSrcVt   = rdEntry.srcVt;

  tsi_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inStrobe (inStrobe),
    .inPort   (inPort),
    .inVt     (inVt),
    .cfgWe    (cfgWe),
    .cfgPort  (cfgPort),
    .cfgVt    (cfgVt),
    .cfgEntry (cfgEntry),
    .rdEntry  (rdEntry),
    .strobes  (strobes)
  );

  tsi_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .outStrobe (outStrobe),
    .outPort   (outPort),
    .outVt     (outVt),
    .outData   (outData)
  );
endmodule

// File: tb/sim_vt_tsi_switch.sv
`timescale 1ns/1ps
module sim_vt_tsi_switch;
  localparam int NP = 24;
  localparam int NV = 28;
  localparam int NT = NP * NV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inStrobe = 1'b0;
  logic [4:0] inPort = '0;
  logic [4:0] inVt = '0;
  logic [7:0] inData = '0;
  logic outStrobe;
  logic [4:0] outPort;
  logic [4:0] outVt;
  logic [7:0] outData;
  logic cfgWe = 1'b0;
  logic [4:0] cfgPort = '0;
  logic [4:0] cfgVt = '0;
  logic cfgConnect = 1'b0;
  logic [4:0] cfgSrcPort = '0;
  logic [4:0] cfgSrcVt = '0;
  logic rdConnect;
  logic [4:0] rdSrcPort;
  logic [4:0] rdSrcVt;

  int nChecks = 0;
  int nErr = 0;
  bit pendConn [NT];
  int pendSrc  [NT];
  bit actConn  [NT];
  int actSrc   [NT];
  bit ready = 0;
  int prevFrame = 0;

  always #2.5 clk = ~clk;

  vt_tsi_switch u0 (.*);

  function automatic logic [7:0] pat(int frame, int idx);
    return 8'((idx * 5 + frame * 37 + 1) & 8'hFE);
  endfunction

  task automatic check(bit ok, string tag, string what, int got, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic cfgWrite(int dst, bit conn, int src);
    @(negedge clk);
    cfgWe = 1'b1; cfgPort = 5'(dst / NV); cfgVt = 5'(dst % NV);
    cfgConnect = conn; cfgSrcPort = 5'(src / NV); cfgSrcVt = 5'(src % NV);
    @(negedge clk);
    cfgWe = 1'b0;
    pendConn[dst] = conn; pendSrc[dst] = src;
  endtask

  // R7: readback of the pending entry
  task automatic checkRead(int dst, string tag);
    cfgPort = 5'(dst / NV); cfgVt = 5'(dst % NV);
    #1;
    check(rdConnect === pendConn[dst], tag, "readback connect", int'(rdConnect), int'(pendConn[dst]));
    if (pendConn[dst])
      check(rdSrcPort === 5'(pendSrc[dst] / NV) && rdSrcVt === 5'(pendSrc[dst] % NV), tag,
            "readback source", int'({rdSrcPort, rdSrcVt}),
            int'({5'(pendSrc[dst] / NV), 5'(pendSrc[dst] % NV)}));
  endtask

  task automatic checkSlot(int k, string frameTag);
    logic [7:0] exp;
    string tag;
    if (!ready) begin exp = 8'hFF; tag = "R6"; end
    else if (!actConn[k]) begin exp = 8'hFF; tag = "R5"; end
    else begin
      exp = pat(prevFrame, actSrc[k]);
      tag = (actSrc[k] == 7 * NV + 9) ? "R4" : "R3";
    end
    if (frameTag != "") tag = {frameTag, "/", tag};
    check(outStrobe === 1'b1 && outPort === 5'(k / NV) && outVt === 5'(k % NV), {tag, "/R2"},
          $sformatf("position slot %0d", k), int'({outStrobe, outPort, outVt}),
          int'({1'b1, 5'(k / NV), 5'(k % NV)}));
    check(outData === exp, tag, $sformatf("data slot %0d", k), int'(outData), int'(exp));
  endtask

  // Runs one frame; an optional configuration write lands at slot midK.
  task automatic runFrame(int frame, string frameTag, int midK, int midDst, bit midConn, int midSrc);
    for (int k = 0; k < NT; k++) begin
      @(negedge clk);
      if (k > 0) checkSlot(k - 1, frameTag);
      cfgWe = 1'b0;
      inStrobe = 1'b1; inPort = 5'(k / NV); inVt = 5'(k % NV); inData = pat(frame, k);
      if (k == midK) begin
        cfgWe = 1'b1; cfgPort = 5'(midDst / NV); cfgVt = 5'(midDst % NV);
        cfgConnect = midConn; cfgSrcPort = 5'(midSrc / NV); cfgSrcVt = 5'(midSrc % NV);
        pendConn[midDst] = midConn; pendSrc[midDst] = midSrc;
      end
    end
    @(negedge clk);
    checkSlot(NT - 1, frameTag);
    inStrobe = 1'b0; cfgWe = 1'b0;
    @(negedge clk);
    check(outStrobe === 1'b0, "R2", "strobe after gap", int'(outStrobe), 0);
    ready = 1; prevFrame = frame;
    for (int i = 0; i < NT; i++) begin actConn[i] = pendConn[i]; actSrc[i] = pendSrc[i]; end
  endtask

  task automatic testReset();
    for (int i = 0; i < NT; i++) begin pendConn[i] = 0; pendSrc[i] = 0; actConn[i] = 0; actSrc[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outStrobe === 1'b0, "R1", "reset strobe", int'(outStrobe), 0);
    checkRead(0, "R1");
    checkRead(NT - 1, "R1");
  endtask

  task automatic testSparse();
    cfgWrite(0, 1, NT - 1);
    cfgWrite(5 * NV + 3, 1, 5 * NV + 3);
    cfgWrite(1 * NV + 1, 1, 7 * NV + 9);
    cfgWrite(2 * NV + 2, 1, 7 * NV + 9);
    checkRead(0, "R7");
    checkRead(2 * NV + 2, "R7");
    runFrame(0, "R6", -1, 0, 0, 0);
    runFrame(1, "", -1, 0, 0, 0);
  endtask

  task automatic testMidWrite();
    runFrame(2, "R8", 100, 10 * NV, 1, 0);
    checkRead(10 * NV, "R7");
    cfgWrite(0, 0, 0);
    checkRead(0, "R7");
    runFrame(3, "R8", -1, 0, 0, 0);
    runFrame(4, "R8", -1, 0, 0, 0);
  endtask

  task automatic testReverse();
    for (int d = 0; d < NT; d++) cfgWrite(d, 1, NT - 1 - d);
    checkRead(NT - 1, "R7");
    runFrame(5, "R8", -1, 0, 0, 0);
    runFrame(6, "R9", -1, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  initial begin
    testReset();
    testSparse();
    testMidWrite();
    testReverse();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule